// File: doc/BRIEF.md
# Multi-core mailbox doorbell bank

This block keeps a bank of 32-bit doorbell words that processor cores use to signal one another. Each core owns four words. A word cannot be written directly. Software ORs bits into it through a set window and removes bits through a separate clear window. This lets several senders post independent flags without a read-modify-write race. Each word drives one pending line for as long as it holds any 1 bit. The interrupt router downstream takes these lines, one 4-bit group per core.

Two bus ports of the same form can reach every word in the same cycle. The bank merges their effects per bit: requests that raise bits are combined, requests that drop bits are combined, and raising beats dropping.

Read data is registered. It appears on the port in the cycle after the request and shows the word as it stood before any write in that same cycle.

Top module: `mbx_doorbell_bank`

## Requirements
- R1: After reset every word is zero, every pending output is low and every read data output is zero.
- R2: A write to byte address 0x80 + 16*core + 4*mailbox ORs the write data into that word at the capturing clock edge.
- R3: A write to byte address 0xC0 + 16*core + 4*mailbox clears, at the capturing edge, every bit of that word that is 1 in the write data.
- R4: Pending output bit 4*core + mailbox is high exactly while that word is non-zero, and it follows the word at the same edge.
- R5: A read (request high, write-enable low) at a clear-window address returns that word on the same port's read data in the following cycle.
- R6: A read at a set-window address also returns that word in the following cycle.
- R7: When one port sets and the other port clears the same word in the same cycle, a bit named by both ends at 1, a bit named only by the clear ends at 0, and every other bit keeps its value.
- R8: When both ports set the same word in the same cycle, the word gains the union of both values. When both ports clear it, the union of both masks is removed.
- R9: Accesses below 0x80, or with byte address bits [1:0] not 00, change no word, and a read there returns zero.
- R10: In the cycle after a cycle with no read on a port, that port's read data is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 2 | Per-port access request |
| we_i | input | 2 | Per-port write enable (1 = write, 0 = read) |
| addr_i | input | 16 | Per-port byte address, 8 bits each, port 0 in the low bits |
| wdata_i | input | 64 | Per-port write data, 32 bits each |
| rdata_o | output | 64 | Per-port registered read data, 32 bits each |
| pend_o | output | 16 | Pending lines, bit 4*core + mailbox |

## Verification
A write takes effect at the edge that captures it, so the word and its pending line are both due one edge later. Read data passes through one register and is also due one edge after the request. It carries the pre-write word when a write hits in the same cycle. The bench drives every stimulus on a falling edge and samples on the next falling edge, half a period after the edge that is due to produce the result. Its expected values come from a per-word model that it updates with the combined set and clear masks of both ports.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic [1:0] {
    APER_NONE = 2'd0,
    APER_SET  = 2'd1,
    APER_CLR  = 2'd2
  } aper_e;
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
  import mbx_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NUM_MBX  = 16,
  parameter int SET_BASE = 'h80,
  localparam int IDX_W   = $clog2(NUM_MBX)
) (
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  output aper_e             aper_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam int APER_BYTES = NUM_MBX * 4;
  localparam int CLR_BASE   = SET_BASE + APER_BYTES;

  logic [31:0] a32, off;

  always_comb begin
    a32    = 32'(addr_i);
    aper_o = APER_NONE;
    off    = '0;
    if (req_i && a32[1:0] == 2'b00) begin
      if (a32 >= 32'(SET_BASE) && a32 < 32'(CLR_BASE)) begin
        aper_o = APER_SET;
        off    = a32 - 32'(SET_BASE);
      end else if (a32 >= 32'(CLR_BASE) && a32 < 32'(CLR_BASE + APER_BYTES)) begin
        aper_o = APER_CLR;
        off    = a32 - 32'(CLR_BASE);
      end
    end
    idx_o = off[IDX_W+1:2];
  end
endmodule

// File: rtl/mbx_word.sv
module mbx_word #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] set_i,
  input  logic [DATA_W-1:0] clr_i,
  output logic [DATA_W-1:0] word_o,
  output logic              pend_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) word_o <= '0;
    else         word_o <= (word_o & ~clr_i) | set_i;
  end

  assign pend_o = |word_o;

  p_set_lands_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((word_o & $past(set_i)) == $past(set_i)));

  p_clr_lands_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~set_i) != '0) |=> ((word_o & $past(clr_i & ~set_i)) == '0));

  p_idle_holds_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i == '0 && clr_i == '0) |=> $stable(word_o));

  p_pend_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend_o && set_i == '0) |=> !pend_o);
endmodule

// File: rtl/mbx_doorbell_bank.sv
module mbx_doorbell_bank
  import mbx_pkg::*;
#(
  parameter int NUM_CORES    = 4,
  parameter int MBX_PER_CORE = 4,
  parameter int DATA_W       = 32,
  parameter int ADDR_W       = 8,
  parameter int NUM_PORTS    = 2,
  parameter int SET_BASE     = 'h80,
  localparam int NUM_MBX     = NUM_CORES * MBX_PER_CORE,
  localparam int IDX_W       = $clog2(NUM_MBX)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_PORTS-1:0]        req_i,
  input  logic [NUM_PORTS-1:0]        we_i,
  input  logic [NUM_PORTS*ADDR_W-1:0] addr_i,
  input  logic [NUM_PORTS*DATA_W-1:0] wdata_i,
  output logic [NUM_PORTS*DATA_W-1:0] rdata_o,
  output logic [NUM_MBX-1:0]          pend_o
);
  aper_e             aper  [NUM_PORTS];
  logic [IDX_W-1:0]  idx   [NUM_PORTS];
  logic [DATA_W-1:0] set_m [NUM_MBX];
  logic [DATA_W-1:0] clr_m [NUM_MBX];
  logic [DATA_W-1:0] word  [NUM_MBX];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    mbx_decode #(
      .ADDR_W  (ADDR_W),
      .NUM_MBX (NUM_MBX),
      .SET_BASE(SET_BASE)
    ) u_dec (
      .req_i (req_i[p]),
      .addr_i(addr_i[p*ADDR_W +: ADDR_W]),
      .aper_o(aper[p]),
      .idx_o (idx[p])
    );

    logic [DATA_W-1:0] rd_d;
    always_comb begin
      rd_d = '0;
      if (!we_i[p] && aper[p] != APER_NONE) rd_d = word[idx[p]];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rdata_o[p*DATA_W +: DATA_W] <= '0;
      else         rdata_o[p*DATA_W +: DATA_W] <= rd_d;
    end

    p_rdata_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(req_i[p] && !we_i[p]) |=> (rdata_o[p*DATA_W +: DATA_W] == '0));
  end

  // merge all ports' write masks per word; set beats clear inside mbx_word
  always_comb begin
    for (int m = 0; m < NUM_MBX; m++) begin
      set_m[m] = '0;
      clr_m[m] = '0;
    end
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (we_i[p]) begin
        if (aper[p] == APER_SET) set_m[idx[p]] |= wdata_i[p*DATA_W +: DATA_W];
        if (aper[p] == APER_CLR) clr_m[idx[p]] |= wdata_i[p*DATA_W +: DATA_W];
      end
    end
  end

  for (genvar m = 0; m < NUM_MBX; m++) begin : g_mbx
    mbx_word #(.DATA_W(DATA_W)) u_word (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (set_m[m]),
      .clr_i (clr_m[m]),
      .word_o(word[m]),
      .pend_o(pend_o[m])
    );
  end

  p_no_write_no_pend_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o == '0 && we_i == '0) |=> (pend_o == '0));
endmodule

// File: tb/mbx_doorbell_bank_tb_top.sv
module mbx_doorbell_bank_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [1:0]  req = 0, we = 0;
  logic [15:0] addr = 0;
  logic [63:0] wdata = 0;
  logic [63:0] rdata;
  logic [15:0] pend;

  int n_vec = 0, n_bad = 0;
  logic [31:0] mdl [16];

  always #10 clk = ~clk;

  mbx_doorbell_bank dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .pend_o(pend)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int dec(input logic [7:0] a, output bit clr);
    clr = a >= 8'hC0;
    if (a[1:0] != 0 || a < 8'h80) return -1;
    return (int'(a) - (clr ? 'hC0 : 'h80)) / 4;
  endfunction

  // one cycle on both ports; driven at negedge, checked at next negedge
  task automatic cyc(input string tag,
                     input bit r0, input bit w0, input logic [7:0] a0, input logic [31:0] d0,
                     input bit r1, input bit w1, input logic [7:0] a1, input logic [31:0] d1);
    logic [31:0] er [2];
    logic [31:0] sm [16];
    logic [31:0] cm [16];
    logic [15:0] ep;
    bit   rr [2];
    bit   ww [2];
    logic [7:0]  aa [2];
    logic [31:0] dd [2];
    rr[0]=r0; ww[0]=w0; aa[0]=a0; dd[0]=d0;
    rr[1]=r1; ww[1]=w1; aa[1]=a1; dd[1]=d1;
    req = {r1, r0}; we = {w1, w0}; addr = {a1, a0}; wdata = {d1, d0};
    for (int m = 0; m < 16; m++) begin sm[m] = 0; cm[m] = 0; end
    for (int p = 0; p < 2; p++) begin
      bit c; int i;
      i = dec(aa[p], c);
      er[p] = 0;
      if (rr[p] && i >= 0) begin
        if (!ww[p]) er[p] = mdl[i];
        else if (c) cm[i] |= dd[p];
        else sm[i] |= dd[p];
      end
    end
    for (int m = 0; m < 16; m++) mdl[m] = (mdl[m] & ~cm[m]) | sm[m];
    @(posedge clk); @(negedge clk);
    for (int m = 0; m < 16; m++) ep[m] = (mdl[m] != 0);
    chk({tag, " rdata0"}, 64'(rdata[31:0]), 64'(er[0]));
    chk({tag, " rdata1"}, 64'(rdata[63:32]), 64'(er[1]));
    chk({tag, " pend R4"}, 64'(pend), 64'(ep));
    req = 0; we = 0;
  endtask

  task automatic rd_all(input string tag);
    for (int m = 0; m < 16; m++)
      cyc(tag, 1, 0, 8'(8'hC0 + 4*m), 0, 1, 0, 8'(8'h80 + 4*m), 0);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int m = 0; m < 16; m++) mdl[m] = 0;
    repeat (2) @(negedge clk);
    chk("R1 pend at reset", 64'(pend), 0);
    chk("R1 rdata at reset", rdata, 0);
    rst_n = 1;
    @(negedge clk);
    rd_all("R1 words zero R5 R6");
    // R2: set every word, each core/mailbox with its own pattern, twice to show OR
    for (int m = 0; m < 16; m++) begin
      cyc("R2 set", 1, 1, 8'(8'h80 + 4*m), 32'h1 << m, 0, 0, 0, 0);
      cyc("R2 or", 0, 0, 0, 0, 1, 1, 8'(8'h80 + 4*m), 32'hA500_0000 ^ (m * 32'h0101_0101));
    end
    rd_all("R5 R6 after set");
    // R3: partial clear, then full clear of odd words (pend drop R4)
    for (int m = 0; m < 16; m++)
      cyc("R3 clr", 1, 1, 8'(8'hC0 + 4*m), 32'h0F0F_0F0F, 0, 0, 0, 0);
    rd_all("R3 readback");
    for (int m = 1; m < 16; m += 2)
      cyc("R3 clr all", 0, 0, 0, 0, 1, 1, 8'(8'hC0 + 4*m), 32'hFFFF_FFFF);
    rd_all("R4 readback");
    // R7: set vs clear collision, both port orderings
    for (int m = 0; m < 16; m++) begin
      cyc("R7 set0 clr1", 1, 1, 8'(8'h80 + 4*m), 32'h00FF_00F0,
                          1, 1, 8'(8'hC0 + 4*m), 32'hFF00_FF0F | 32'h00F0_0000);
      cyc("R7 clr0 set1", 1, 1, 8'(8'hC0 + 4*m), 32'hFFFF_FFFF,
                          1, 1, 8'(8'h80 + 4*m), 32'h8000_0001 << (m % 4));
    end
    rd_all("R7 readback");
    // R8: union of two sets and of two clears
    for (int m = 0; m < 16; m++) begin
      cyc("R8 set union", 1, 1, 8'(8'h80 + 4*m), 32'h1234_0000, 1, 1, 8'(8'h80 + 4*m), 32'h0000_5678);
      cyc("R8 clr union", 1, 1, 8'(8'hC0 + 4*m), 32'h1200_0000, 1, 1, 8'(8'hC0 + 4*m), 32'h0000_0078);
    end
    rd_all("R8 readback");
    // R5: read and write same word same cycle returns pre-write word
    cyc("R5 rd before wr", 1, 0, 8'hC4, 0, 1, 1, 8'h84, 32'h4000_0000);
    // R9: writes and reads outside apertures or misaligned
    for (int a = 0; a < 256; a++) begin
      if (a >= 'h80 && (a % 4) == 0) continue;
      cyc("R9 stray", 1, 1, 8'(a), 32'hFFFF_FFFF, 1, 0, 8'(a), 0);
    end
    rd_all("R9 readback");
    // R10: idle and write cycles give zero read data
    cyc("R10 idle", 0, 0, 8'hC0, 0, 0, 0, 8'h80, 0);
    cyc("R10 write", 1, 1, 8'hC8, 32'h1, 1, 1, 8'h8C, 32'h0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule